// File: doc/BRIEF.md
# Camera Sensor Input Timing Qualifier

This block sits at the entry of a parallel camera input path. It brings the vertical sync, horizontal sync and external field signals into the local clock domain, corrects their polarity, and finds their active edges. From these it keeps a field identifier, sampled by one of four rules chosen by a two-bit mode. It also qualifies each pixel sample by combining an internal valid signal with an external write enable, marks which qualified samples carry luma, and formats the pixel into a memory word. The word can be narrowed to 8 bits and can have its two bytes exchanged.

A static configuration word drives all options. The word is captured only on an active vertical-sync edge, so a new setting never lands in the middle of a frame. The captured copy is presented back on an output, and the unused bits of that copy always read zero.

Top module: `cam_input_qualifier`

## Requirements
- R1: While reset is asserted and after reset, field_id_o, wr_valid_o, luma_o, wr_data_o and cfg_applied_o are all 0. The applied configuration keeps value 0 until the first active VD edge.
- R2: VD, HD and FLD each pass through two synchroniser flops. "Active" means the synchronised level XOR the polarity bit, where bit 8 is for VD and bit 9 is for HD, and 1 selects active-low. An active edge is an inactive-to-active change between consecutive synchronised samples. A raw change driven before clock edge k takes effect at clock edge k+2.
- R3: When field mode is 0 (cfg bits 1:0), field_id_o takes the synchronised FLD level at an active HD edge that happens while VD is active. At every other time it holds.
- R4: When field mode is 1, field_id_o follows the synchronised FLD level on every clock, with no latching condition.
- R5: When field mode is 2, field_id_o takes the synchronised FLD level only at an active VD edge.
- R6: When field mode is 3, field_id_o takes the synchronised FLD level on every clock in which VD is active and HD is inactive.
- R7: wr_valid_o is registered one clock after its inputs. It equals int_valid_i AND wen_i when cfg bit 2 is 0, and int_valid_i OR wen_i when cfg bit 2 is 1.
- R8: A pixel index restarts at 0 on the sample that coincides with an active HD edge. The index advances by one after each qualified sample. luma_o is 1 only on a qualified sample whose index parity equals cfg bit 3, where 0 means luma on even pixels and 1 means luma on odd pixels.
- R9: The sample is 10-bit wide when cfg bit 4 (BT.656 on) selects cfg bit 5, or otherwise when cfg bit 6 says so. A 10-bit sample is placed as {6'b0, pix_i}. An 8-bit sample keeps pix_i[9:2], forces the two low bits to 0, and uses the same placement. wr_data_o is registered one clock after pix_i.
- R10: When cfg bit 7 is 1, the two bytes of the 16-bit word are exchanged. When it is 0, the word is unchanged.
- R11: The configuration word is captured only at an active VD edge. The field and write logic use the previous applied value in that same clock. cfg_applied_o shows the applied value, and bits 15:10 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word_i | input | 16 | Pending configuration word |
| vd_i | input | 1 | Raw vertical sync |
| hd_i | input | 1 | Raw horizontal sync |
| fld_i | input | 1 | Raw external field signal |
| pix_i | input | 10 | Pixel sample |
| int_valid_i | input | 1 | Internal sample-valid |
| wen_i | input | 1 | External write enable |
| field_id_o | output | 1 | Latched field identifier |
| wr_valid_o | output | 1 | Qualified write strobe |
| luma_o | output | 1 | Qualified sample is luma |
| wr_data_o | output | 16 | Formatted memory word |
| cfg_applied_o | output | 16 | Configuration currently in force |

## Verification
The bench builds the block with its default parameters: a 10-bit pixel bus, an 8-bit narrow mode, a 16-bit memory word, two synchroniser stages and a 12-bit pixel index. With these values the narrow and wide formats differ by exactly two zeroed low bits, and the byte exchange crosses the bus boundary. With syncs toggled every few tens of clocks, frame and line edges come often enough that every field mode, both polarities and the deferred configuration capture each occur hundreds of times in a short run. The index parity also rolls over on every line.

// File: rtl/cam_qual_pkg.sv
// Package: shared configuration layout for the sensor input qualifier.
// Assumes a 16-bit configuration word; bits 15:10 are unused and forced to 0.
package cam_qual_pkg;

    localparam int CFG_W = 16;

    // Field sampling rules.
    typedef enum logic [1:0] {
        FLD_HD_IN_VD  = 2'd0,
        FLD_PASS      = 2'd1,
        FLD_VD_EDGE   = 2'd2,
        FLD_VD_NOT_HD = 2'd3
    } fld_mode_e;

    // Configuration word, MSB first.
    typedef struct packed {
        logic [5:0] rsvd;        // 15:10
        logic       hd_low;      // 9
        logic       vd_low;      // 8
        logic       swap;        // 7
        logic       gen_wide;    // 6
        logic       bt656_wide;  // 5
        logic       bt656_en;    // 4
        logic       y_odd;       // 3
        logic       valid_or;    // 2
        fld_mode_e  fmode;       // 1:0
    } cfg_t;

    localparam logic [CFG_W-1:0] CFG_LIVE_MASK = 16'h03FF;

endpackage

// File: rtl/cam_sync_bank.sv
// Module: bank of multi-flop synchronisers, one chain per bit.
// Assumes inputs are asynchronous levels; output is the last stage.
module cam_sync_bank #(
    parameter int N      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);

    for (genvar g = 0; g < N; g++) begin : g_chain
        logic [STAGES-1:0] chain_q;

        // Shift the raw level through the synchroniser stages.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cam_edge_det.sv
// Module: polarity correction and active-edge detection of one synchronised sync.
// Assumes sync_i is already in the clk domain; pol_low=1 means active-low.
module cam_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic pol_low,
    output logic act_o,
    output logic edge_o
);

    logic prev_q;

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    assign act_o  = sync_i ^ pol_low;
    assign edge_o = act_o & ~(prev_q ^ pol_low);

endmodule

// File: rtl/cam_field_latch.sv
// Module: field identifier register with four sampling rules.
// Assumes all inputs are synchronised and polarity-corrected.
module cam_field_latch
    import cam_qual_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fld_mode_e mode_i,
    input  logic      fld_s_i,
    input  logic      vd_act_i,
    input  logic      vd_edge_i,
    input  logic      hd_act_i,
    input  logic      hd_edge_i,
    output logic      field_id_o
);

    logic take;

    // Decide whether the field level is sampled this clock.
    always_comb begin
        unique case (mode_i)
            FLD_HD_IN_VD:  take = vd_act_i & hd_edge_i;
            FLD_PASS:      take = 1'b1;
            FLD_VD_EDGE:   take = vd_edge_i;
            FLD_VD_NOT_HD: take = vd_act_i & ~hd_act_i;
            default:       take = 1'b0;
        endcase
    end

    // Hold or update the field identifier.
    always_ff @(posedge clk) begin
        if (!rst_n)    field_id_o <= 1'b0;
        else if (take) field_id_o <= fld_s_i;
    end

endmodule

// File: rtl/cam_write_path.sv
// Module: sample qualification, luma flagging and memory word formatting.
// Assumes pix_i, int_valid_i and wen_i are synchronous to clk.
module cam_write_path #(
    parameter int DIN_W    = 10,
    parameter int NARROW_W = 8,
    parameter int WORD_W   = 16,
    parameter int CNT_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_or_i,
    input  logic              y_odd_i,
    input  logic              bt656_en_i,
    input  logic              bt656_wide_i,
    input  logic              gen_wide_i,
    input  logic              swap_i,
    input  logic              hd_edge_i,
    input  logic [DIN_W-1:0]  pix_i,
    input  logic              int_valid_i,
    input  logic              wen_i,
    output logic              wr_valid_o,
    output logic              luma_o,
    output logic [WORD_W-1:0] wr_data_o
);

    localparam int HALF = WORD_W / 2;
    localparam logic [DIN_W-1:0] LOW_MASK = DIN_W'((1 << (DIN_W - NARROW_W)) - 1);

    logic              qual;
    logic              wide;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt_q;
    logic [DIN_W-1:0]  sample;
    logic [WORD_W-1:0] word;

    // Combine the two valid sources.
    assign qual = valid_or_i ? (int_valid_i | wen_i) : (int_valid_i & wen_i);

    // BT.656 width overrides the general width.
    assign wide = bt656_en_i ? bt656_wide_i : gen_wide_i;

    // Pixel index of the current sample, restarting on a line edge.
    assign idx = hd_edge_i ? '0 : cnt_q;

    // Format the sample and apply the optional byte exchange.
    always_comb begin
        sample = wide ? pix_i : (pix_i & ~LOW_MASK);
        word   = WORD_W'(sample);
        if (swap_i) word = {word[HALF-1:0], word[WORD_W-1:HALF]};
    end

    // Advance the pixel index on qualified samples.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (qual) cnt_q <= idx + CNT_W'(1);
        else           cnt_q <= idx;
    end

    // Register the write outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_o <= 1'b0;
            luma_o     <= 1'b0;
            wr_data_o  <= '0;
        end else begin
            wr_valid_o <= qual;
            luma_o     <= qual & (idx[0] == y_odd_i);
            wr_data_o  <= word;
        end
    end

endmodule

// File: rtl/cam_input_qualifier.sv
// Module: top of the sensor input timing qualifier.
// Assumes cfg_word_i is quasi-static; it is captured only on an active VD edge.
module cam_input_qualifier
    import cam_qual_pkg::*;
#(
    parameter int DIN_W    = 10,
    parameter int NARROW_W = 8,
    parameter int WORD_W   = 16,
    parameter int STAGES   = 2,
    parameter int CNT_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word_i,
    input  logic              vd_i,
    input  logic              hd_i,
    input  logic              fld_i,
    input  logic [DIN_W-1:0]  pix_i,
    input  logic              int_valid_i,
    input  logic              wen_i,
    output logic              field_id_o,
    output logic              wr_valid_o,
    output logic              luma_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic [CFG_W-1:0]  cfg_applied_o
);

    cfg_t       cfg_q;
    logic [2:0] sync_s;
    logic       vd_act, vd_edge, hd_act, hd_edge;

    // Bring the three sync-type inputs into the clock domain.
    cam_sync_bank #(.N(3), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({fld_i, hd_i, vd_i}),
        .sync_o (sync_s)
    );

    cam_edge_det u_vd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_s[0]),
        .pol_low (cfg_q.vd_low),
        .act_o   (vd_act),
        .edge_o  (vd_edge)
    );

    cam_edge_det u_hd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_s[1]),
        .pol_low (cfg_q.hd_low),
        .act_o   (hd_act),
        .edge_o  (hd_edge)
    );

    // Capture the configuration at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (vd_edge) cfg_q <= cfg_t'(cfg_word_i & CFG_LIVE_MASK);
    end

    assign cfg_applied_o = cfg_q;

    cam_field_latch u_fld (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (cfg_q.fmode),
        .fld_s_i    (sync_s[2]),
        .vd_act_i   (vd_act),
        .vd_edge_i  (vd_edge),
        .hd_act_i   (hd_act),
        .hd_edge_i  (hd_edge),
        .field_id_o (field_id_o)
    );

    cam_write_path #(
        .DIN_W(DIN_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
    ) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_or_i   (cfg_q.valid_or),
        .y_odd_i      (cfg_q.y_odd),
        .bt656_en_i   (cfg_q.bt656_en),
        .bt656_wide_i (cfg_q.bt656_wide),
        .gen_wide_i   (cfg_q.gen_wide),
        .swap_i       (cfg_q.swap),
        .hd_edge_i    (hd_edge),
        .pix_i        (pix_i),
        .int_valid_i  (int_valid_i),
        .wen_i        (wen_i),
        .wr_valid_o   (wr_valid_o),
        .luma_o       (luma_o),
        .wr_data_o    (wr_data_o)
    );

endmodule

// File: rtl/cam_input_qualifier_chk.sv
// Module: assertion checker bound to the qualifier top.
// Assumes the default configuration bit layout of cam_qual_pkg.
module cam_input_qualifier_chk #(
    parameter int DIN_W    = 10,
    parameter int NARROW_W = 8,
    parameter int WORD_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cfg_applied_o,
    input logic              vd_edge,
    input logic              vd_act,
    input logic              hd_edge,
    input logic              hd_act,
    input logic              field_id_o,
    input logic              wr_valid_o,
    input logic              luma_o,
    input logic [WORD_W-1:0] wr_data_o,
    input logic              int_valid_i,
    input logic              wen_i
);

    logic narrow;
    assign narrow = !(cfg_applied_o[4] ? cfg_applied_o[5] : cfg_applied_o[6]);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_applied_o[15:10] == 6'd0);

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vd_edge |=> $stable(cfg_applied_o));

    // R7
    valid_combine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wr_valid_o == ($past(cfg_applied_o[2]) ? $past(int_valid_i | wen_i)
                                                        : $past(int_valid_i & wen_i)));

    // R8
    luma_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        luma_o |-> wr_valid_o);

    // R3
    fld_hd_in_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_applied_o[1:0] == 2'd0 && !(vd_act && hd_edge)) |=> $stable(field_id_o));

    // R5
    fld_vd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_applied_o[1:0] == 2'd2 && !vd_edge) |=> $stable(field_id_o));

    // R6
    fld_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_applied_o[1:0] == 2'd3 && !(vd_act && !hd_act)) |=> $stable(field_id_o));

    // R9
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && !cfg_applied_o[7]) |=>
            (wr_data_o[DIN_W-NARROW_W-1:0] == '0 && wr_data_o[WORD_W-1:DIN_W] == '0));

endmodule

bind cam_input_qualifier cam_input_qualifier_chk #(
    .DIN_W(DIN_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_applied_o (cfg_applied_o),
    .vd_edge       (vd_edge),
    .vd_act        (vd_act),
    .hd_edge       (hd_edge),
    .hd_act        (hd_act),
    .field_id_o    (field_id_o),
    .wr_valid_o    (wr_valid_o),
    .luma_o        (luma_o),
    .wr_data_o     (wr_data_o),
    .int_valid_i   (int_valid_i),
    .wen_i         (wen_i)
);

// File: tb/sim_cam_input_qualifier.sv
`timescale 1ns/1ps
// Bench: random and directed stimulus checked against a cycle model built from R1..R11.
module sim_cam_input_qualifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        vd = 1'b0, hd = 1'b0, fld = 1'b0;
    logic [9:0]  pix = '0;
    logic        iv = 1'b0, wen = 1'b0;
    logic        field_id, wr_valid, luma;
    logic [15:0] wr_data, cfg_applied;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cam_input_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word_i(cfg_word),
        .vd_i(vd), .hd_i(hd), .fld_i(fld), .pix_i(pix),
        .int_valid_i(iv), .wen_i(wen),
        .field_id_o(field_id), .wr_valid_o(wr_valid), .luma_o(luma),
        .wr_data_o(wr_data), .cfg_applied_o(cfg_applied)
    );

    // Model state: raw history per sync bit {fld,hd,vd}.
    logic [2:0]  m1, m2, m3;
    logic [15:0] m_cfg, m_data;
    logic        m_fld, m_wv, m_luma;
    int unsigned m_cnt;
    string       m_freq;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fmt(input logic [9:0] p, input logic [15:0] c);
        logic        wide;
        logic [15:0] w;
        wide = c[4] ? c[5] : c[6];
        w = wide ? {6'b0, p} : {6'b0, p[9:2], 2'b00};
        if (c[7]) w = {w[7:0], w[15:8]};
        return w;
    endfunction

    task automatic model_reset();
        m1 = '0; m2 = '0; m3 = '0; m_cfg = '0; m_data = '0;
        m_fld = 1'b0; m_wv = 1'b0; m_luma = 1'b0; m_cnt = 0;
    endtask

    // One clock: advance the model, clock the design, compare at the falling edge.
    task automatic cycle();
        logic        va, vp, ha, hp, ve, he, fs, q;
        int unsigned idx;
        va = m2[0] ^ m_cfg[8]; vp = m3[0] ^ m_cfg[8];
        ha = m2[1] ^ m_cfg[9]; hp = m3[1] ^ m_cfg[9];
        ve = va & ~vp; he = ha & ~hp; fs = m2[2];
        case (m_cfg[1:0])
            2'd0: begin m_freq = "R3"; if (va && he) m_fld = fs; end
            2'd1: begin m_freq = "R4"; m_fld = fs; end
            2'd2: begin m_freq = "R5"; if (ve) m_fld = fs; end
            default: begin m_freq = "R6"; if (va && !ha) m_fld = fs; end
        endcase
        q = m_cfg[2] ? (iv | wen) : (iv & wen);
        idx = he ? 0 : m_cnt;
        m_wv = q;
        m_luma = q && (idx[0] == m_cfg[3]);
        m_cnt = q ? idx + 1 : idx;
        m_data = fmt(pix, m_cfg);
        if (ve) m_cfg = cfg_word & 16'h03FF;
        m3 = m2; m2 = m1; m1 = {fld, hd, vd};
        @(posedge clk);
        @(negedge clk);
        check(field_id === m_fld, m_freq, "field_id", 32'(field_id), 32'(m_fld));
        check(wr_valid === m_wv, "R7", "wr_valid", 32'(wr_valid), 32'(m_wv));
        check(luma === m_luma, "R8", "luma", 32'(luma), 32'(m_luma));
        check(wr_data === m_data, "R9/R10", "wr_data", 32'(wr_data), 32'(m_data));
        check(cfg_applied === m_cfg, "R11", "cfg_applied", 32'(cfg_applied), 32'(m_cfg));
    endtask

    task automatic pulse_vd(input int hold);
        vd = ~vd;
        repeat (hold) cycle();
        vd = ~vd;
        repeat (hold) cycle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // R1: reset holds all outputs at zero, even with busy inputs.
        repeat (4) begin
            pix = 10'($urandom); iv = 1'b1; wen = 1'b1; vd = ~vd; fld = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        check(field_id === 1'b0 && wr_valid === 1'b0 && luma === 1'b0,
              "R1", "flags in reset", {29'd0, field_id, wr_valid, luma}, 32'd0);
        check(wr_data === 16'd0 && cfg_applied === 16'd0,
              "R1", "words in reset", {wr_data, cfg_applied}, 32'd0);
        vd = 1'b0; hd = 1'b0; fld = 1'b0; iv = 1'b0; wen = 1'b0;
        rst_n = 1'b1;
        model_reset();

        // R11: reserved bits drop; configuration waits for the VD edge.
        cfg_word = 16'hFFFF;
        repeat (5) cycle();
        check(cfg_applied === 16'h0000, "R11", "before VD edge", 32'(cfg_applied), 32'h0);
        pulse_vd(4);
        check(cfg_applied === 16'h03FF, "R11", "reserved read zero", 32'(cfg_applied), 32'h03FF);

        // R10: wide swap of a known value (active-low VD now in force, R2).
        cfg_word = 16'h00C0;
        pulse_vd(4);
        pix = 10'h3A5; iv = 1'b1; wen = 1'b1;
        cycle();
        check(wr_data === 16'hA503, "R10", "swap wide", 32'(wr_data), 32'hA503);

        // R9: BT.656 narrow overrides general wide.
        cfg_word = 16'h0050;
        pulse_vd(4);
        pix = 10'h3A7;
        cycle();
        check(wr_data === 16'h03A4, "R9", "656 narrow", 32'(wr_data), 32'h03A4);

        // R2..R8: random phases, each field mode in turn.
        for (int md = 0; md < 4; md++) begin
            for (int c = 0; c < 3000; c++) begin
                if (c % 300 == 0) cfg_word = {6'd0, 8'($urandom), 2'(md)};
                if ($urandom % 30 == 0) vd = ~vd;
                if ($urandom % 7 == 0)  hd = ~hd;
                if ($urandom % 11 == 0) fld = ~fld;
                pix = 10'($urandom);
                iv  = 1'($urandom);
                wen = 1'($urandom);
                cycle();
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule